// File: doc/BRIEF.md
# Pointer-Relative Short Load/Store Unit

This block turns a 16-bit compact load or store instruction into a single-beat memory request. The address is a dedicated base pointer plus a small unsigned displacement that is packed into the instruction and scaled by the access size. The request goes out in the same cycle the instruction is presented. Any encoding the unit does not know raises an illegal flag, and no request is made for it.

For loads, the unit remembers the destination register and the lane position of the access. When the memory returns its read data, the unit picks out the addressed halfword or word and writes it back through a register-file write port one cycle later. Halfword loads are zero-extended. For stores, the unit copies the low byte, halfword or word of the source register into every lane of the write bus and enables only the lanes that the address selects.

Top module: `ptr_short_lsu`

## Requirements
- R1: Instruction bits 15:11 name the data register, and the request address is the base pointer plus the zero-extended, scaled displacement, wrapping modulo 2^AW.
- R2: Bits 10:4 = 0000111 decode as a halfword load. The displacement is bits 3:0 times 2, and the request shows mem_req=1, mem_we=0, mem_size=1 in the same cycle as inst_valid.
- R3: Bits 10:7 = 1010 with bit 0 = 0 decode as a word load. The displacement is bits 6:1 times 4, and the request shows mem_we=0, mem_size=2 and all byte enables set.
- R4: Bits 10:7 = 1010 with bit 0 = 1 decode as a word store. It uses the same displacement as R3, drives mem_we=1, mem_size=2, mem_wdata equal to the full register and all four byte enables.
- R5: Bits 10:7 = 0111 decode as a byte store. The displacement is bits 6:0 unscaled, mem_size=0, the register's low byte is copied to every lane, and only byte enable bit addr[1:0] is set.
- R6: Bits 10:7 = 1001 decode as a halfword store. The displacement is bits 6:0 times 2, mem_size=1, the register's low halfword is copied to both halves, and the byte enables are 0011 when addr[1]=0 and 1100 when addr[1]=1.
- R7: When inst_valid is high with any other encoding, illegal=1 and mem_req=0 in that cycle. When inst_valid is low, both mem_req and illegal stay 0.
- R8: One cycle after mem_rvalid for an outstanding load, rf_we pulses once. rf_waddr is the load's register, and rf_wdata is the full word (word load) or the halfword selected by addr[1], zero-extended (halfword load).
- R9: mem_rvalid with no load outstanding, including after a store, produces no writeback.
- R10: While reset is held, mem_req, illegal, rf_we and mem_be are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inst_valid | input | 1 | Instruction present this cycle |
| inst | input | 16 | Compact instruction halfword |
| ep_val | input | 32 | Base pointer register value |
| reg2_rdata | input | 32 | Read data of the named data register |
| mem_req | output | 1 | Memory request strobe |
| mem_addr | output | AW | Request byte address |
| mem_wdata | output | BUS_W | Store data, copied across lanes |
| mem_size | output | 2 | Access size: 0 byte, 1 halfword, 2 word |
| mem_we | output | 1 | Write strobe (store) |
| mem_be | output | BUS_W/8 | Byte lane enables |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | BUS_W | Read data |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | 5 | Register write index |
| rf_wdata | output | 32 | Register write data |
| illegal | output | 1 | Unrecognised encoding presented |

## Verification
The assertions check several properties on every cycle. The lane-enable population matches the access size, illegal and idle cycles never carry a request, loads never use the byte size, and a writeback is always preceded by read-valid and an outstanding load. Issuing a store also never leaves a load outstanding. Other behaviour can only be shown by the bench's scenarios, because it depends on exact values. This covers the decoded displacement scaling for each format, address wrap-around, the placement of replicated store data, the choice of halfword lane on load return, and the destination index.

// File: rtl/psl_pkg.sv
package psl_pkg;
   localparam int REG_W  = 32;
   localparam int RID_W  = 5;
   localparam int DISP_W = 8;
   localparam int INST_W = 16;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_LDH,
      OP_LDW,
      OP_STB,
      OP_STH,
      OP_STW
   } op_e;

   typedef enum logic [1:0] {
      SZ_B = 2'd0,
      SZ_H = 2'd1,
      SZ_W = 2'd2
   } size_e;

   typedef struct packed {
      logic              legal;
      logic              is_load;
      logic              is_store;
      size_e             size;
      logic [RID_W-1:0]  rid;
      logic [DISP_W-1:0] disp;
   } dec_t;
endpackage

// File: rtl/psl_decode.sv
module psl_decode
   import psl_pkg::*;
(
   input  logic [INST_W-1:0] inst,
   output dec_t              dec
);
   op_e op;

   // format recognition; the halfword-load pattern is checked first
   always_comb begin
      op = OP_NONE;
      if (inst[10:4] == 7'b0000111) begin
         op = OP_LDH;
      end else begin
         case (inst[10:7])
            4'b1010: op = inst[0] ? OP_STW : OP_LDW;
            4'b0111: op = OP_STB;
            4'b1001: op = OP_STH;
            default: op = OP_NONE;
         endcase
      end
   end

   // field extraction and displacement scaling
   always_comb begin
      dec      = '0;
      dec.rid  = inst[15:11];
      dec.size = SZ_B;
      case (op)
         OP_LDH: begin
            dec.legal   = 1'b1;
            dec.is_load = 1'b1;
            dec.size    = SZ_H;
            dec.disp    = {3'b000, inst[3:0], 1'b0};
         end
         OP_LDW: begin
            dec.legal   = 1'b1;
            dec.is_load = 1'b1;
            dec.size    = SZ_W;
            dec.disp    = {inst[6:1], 2'b00};
         end
         OP_STW: begin
            dec.legal    = 1'b1;
            dec.is_store = 1'b1;
            dec.size     = SZ_W;
            dec.disp     = {inst[6:1], 2'b00};
         end
         OP_STB: begin
            dec.legal    = 1'b1;
            dec.is_store = 1'b1;
            dec.size     = SZ_B;
            dec.disp     = {1'b0, inst[6:0]};
         end
         OP_STH: begin
            dec.legal    = 1'b1;
            dec.is_store = 1'b1;
            dec.size     = SZ_H;
            dec.disp     = {inst[6:0], 1'b0};
         end
         default: dec.legal = 1'b0;
      endcase
   end
endmodule

// File: rtl/psl_agen.sv
module psl_agen
   import psl_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic [REG_W-1:0]  base,
   input  logic [DISP_W-1:0] disp,
   output logic [AW-1:0]     addr
);
   // unsigned offset, wraps at the address width
   assign addr = base[AW-1:0] + AW'(disp);
endmodule

// File: rtl/psl_store_lanes.sv
module psl_store_lanes
   import psl_pkg::*;
#(
   parameter int BUS_W = 32
) (
   input  size_e               size,
   input  logic [$clog2(BUS_W/8)-1:0] off,
   input  logic [REG_W-1:0]    src,
   output logic [BUS_W-1:0]    wdata,
   output logic [BUS_W/8-1:0]  be
);
   localparam int NB   = BUS_W / 8;
   localparam int LOFF = $clog2(NB);
   localparam int LNW  = LOFF + 1;

   logic [LOFF-1:0] base;
   logic [LOFF:0]   nbytes;
   logic [LOFF:0]   first;
   logic [LOFF:0]   last_x;

   always_comb begin
      case (size)
         SZ_B:    begin base = off;                 nbytes = LNW'(1); end
         SZ_H:    begin base = off & ~LOFF'(1);     nbytes = LNW'(2); end
         default: begin base = off & ~LOFF'(3);     nbytes = LNW'(4); end
      endcase
   end

   assign first  = {1'b0, base};
   assign last_x = first + nbytes;

   for (genvar i = 0; i < NB; i++) begin : g_lane
      localparam logic [LOFF:0] LANE = LNW'(i);
      assign be[i] = (first <= LANE) && (LANE < last_x);
      assign wdata[8*i +: 8] = (size == SZ_B) ? src[7:0] :
                               (size == SZ_H) ? src[8*(i%2) +: 8] :
                                                src[8*(i%4) +: 8];
   end
endmodule

// File: rtl/psl_load_wb.sv
module psl_load_wb
   import psl_pkg::*;
#(
   parameter int BUS_W = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       issue_load,
   input  logic                       issue_store,
   input  logic [RID_W-1:0]           ld_rid,
   input  size_e                      ld_size,
   input  logic [$clog2(BUS_W/8)-1:0] ld_off,
   input  logic                       mem_rvalid,
   input  logic [BUS_W-1:0]           mem_rdata,
   output logic                       rf_we,
   output logic [RID_W-1:0]           rf_waddr,
   output logic [REG_W-1:0]           rf_wdata
);
   localparam int LOFF = $clog2(BUS_W / 8);

   logic             pend_v;
   logic [RID_W-1:0] pend_rid;
   logic             pend_half;
   logic [LOFF-1:0]  pend_base;
   logic [LOFF-1:0]  cap_base;
   logic [BUS_W-1:0] shifted;
   logic [REG_W-1:0] ext_data;

   assign cap_base = (ld_size == SZ_H) ? (ld_off & ~LOFF'(1)) : (ld_off & ~LOFF'(3));

   // load context: a new load replaces it, read return retires it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v    <= 1'b0;
         pend_rid  <= '0;
         pend_half <= 1'b0;
         pend_base <= '0;
      end else if (issue_load) begin
         pend_v    <= 1'b1;
         pend_rid  <= ld_rid;
         pend_half <= (ld_size == SZ_H);
         pend_base <= cap_base;
      end else if (mem_rvalid) begin
         pend_v    <= 1'b0;
      end
   end

   assign shifted  = mem_rdata >> {pend_base, 3'b000};
   assign ext_data = pend_half ? {16'h0000, shifted[15:0]} : shifted[REG_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rf_we    <= 1'b0;
         rf_waddr <= '0;
         rf_wdata <= '0;
      end else begin
         rf_we    <= mem_rvalid && pend_v;
         rf_waddr <= pend_rid;
         rf_wdata <= ext_data;
      end
   end

   a_r8_wb_needs_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> $past(mem_rvalid));

   a_r9_wb_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> $past(pend_v));

   a_r9_store_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_store && !pend_v) |=> !pend_v);
endmodule

// File: rtl/ptr_short_lsu.sv
module ptr_short_lsu
   import psl_pkg::*;
#(
   parameter int AW    = 32,
   parameter int BUS_W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 inst_valid,
   input  logic [15:0]          inst,
   input  logic [31:0]          ep_val,
   input  logic [31:0]          reg2_rdata,
   output logic                 mem_req,
   output logic [AW-1:0]        mem_addr,
   output logic [BUS_W-1:0]     mem_wdata,
   output logic [1:0]           mem_size,
   output logic                 mem_we,
   output logic [BUS_W/8-1:0]   mem_be,
   input  logic                 mem_rvalid,
   input  logic [BUS_W-1:0]     mem_rdata,
   output logic                 rf_we,
   output logic [4:0]           rf_waddr,
   output logic [31:0]          rf_wdata,
   output logic                 illegal
);
   localparam int NB   = BUS_W / 8;
   localparam int LOFF = $clog2(NB);

   if (!(BUS_W == 32 || BUS_W == 64)) begin : g_bad_bus
      $error("BUS_W must be 32 or 64");
   end
   if (AW < DISP_W || AW > REG_W) begin : g_bad_aw
      $error("AW must lie between the displacement width and the register width");
   end

   dec_t            dec;
   logic [NB-1:0]   be_raw;
   logic [AW-1:0]   addr;

   psl_decode u_dec (
      .inst (inst),
      .dec  (dec)
   );

   psl_agen #(.AW(AW)) u_agen (
      .base (ep_val),
      .disp (dec.disp),
      .addr (addr)
   );

   psl_store_lanes #(.BUS_W(BUS_W)) u_lanes (
      .size  (dec.size),
      .off   (addr[LOFF-1:0]),
      .src   (reg2_rdata),
      .wdata (mem_wdata),
      .be    (be_raw)
   );

   assign mem_req  = inst_valid && dec.legal;
   assign illegal  = inst_valid && !dec.legal;
   assign mem_we   = mem_req && dec.is_store;
   assign mem_size = dec.size;
   assign mem_addr = addr;
   assign mem_be   = mem_req ? be_raw : '0;

   psl_load_wb #(.BUS_W(BUS_W)) u_wb (
      .clk         (clk),
      .rst_n       (rst_n),
      .issue_load  (mem_req && dec.is_load),
      .issue_store (mem_we),
      .ld_rid      (dec.rid),
      .ld_size     (dec.size),
      .ld_off      (addr[LOFF-1:0]),
      .mem_rvalid  (mem_rvalid),
      .mem_rdata   (mem_rdata),
      .rf_we       (rf_we),
      .rf_waddr    (rf_waddr),
      .rf_wdata    (rf_wdata)
   );

   a_r7_illegal_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> !mem_req);

   a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !inst_valid |-> (!mem_req && !illegal && mem_be == '0));

   a_r5_byte_be_single: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_size == SZ_B) |-> $countones(mem_be) == 1);

   a_r6_half_be_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_size == SZ_H) |-> $countones(mem_be) == 2);

   a_r4_word_be_full: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_size == SZ_W) |-> $countones(mem_be) == 4);

   a_r2_load_not_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> mem_size != SZ_B);
endmodule

// File: tb/sim_ptr_short_lsu.sv
module sim_ptr_short_lsu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        inst_valid = 1'b0;
   logic [15:0] inst = '0;
   logic [31:0] ep_val = '0;
   logic [31:0] reg2_rdata = '0;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [1:0]  mem_size;
   logic        mem_we;
   logic [3:0]  mem_be;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        rf_we;
   logic [4:0]  rf_waddr;
   logic [31:0] rf_wdata;
   logic        illegal;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;

   always #2 clk = ~clk;

   ptr_short_lsu u0 (
      .clk(clk), .rst_n(rst_n), .inst_valid(inst_valid), .inst(inst),
      .ep_val(ep_val), .reg2_rdata(reg2_rdata), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_size(mem_size),
      .mem_we(mem_we), .mem_be(mem_be), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
      .rf_wdata(rf_wdata), .illegal(illegal)
   );

   typedef struct {
      string       tag;
      bit          ill;
      bit          req;
      bit          we;
      logic [1:0]  size;
      logic [31:0] addr;
      logic [31:0] wdata;
      logic [3:0]  be;
   } req_t;

   typedef struct {
      string       tag;
      logic [4:0]  rid;
      logic [31:0] data;
   } wb_t;

   req_t rq[$];
   wb_t  wq[$];

   function automatic logic [15:0] e_ldh(input logic [4:0] r, input logic [3:0] d);
      return {r, 7'b0000111, d};
   endfunction
   function automatic logic [15:0] e_ldw(input logic [4:0] r, input logic [5:0] d);
      return {r, 4'b1010, d, 1'b0};
   endfunction
   function automatic logic [15:0] e_stw(input logic [4:0] r, input logic [5:0] d);
      return {r, 4'b1010, d, 1'b1};
   endfunction
   function automatic logic [15:0] e_stb(input logic [4:0] r, input logic [6:0] d);
      return {r, 4'b0111, d};
   endfunction
   function automatic logic [15:0] e_sth(input logic [4:0] r, input logic [6:0] d);
      return {r, 4'b1001, d};
   endfunction

   // expected request derived from the requirement text
   function automatic req_t model(input logic [15:0] ins, input logic [31:0] ep,
                                  input logic [31:0] r2, input string tag);
      req_t e;
      logic [7:0] d;
      int kind;
      e.tag = tag; e.ill = 0; e.req = 1; e.we = 0; e.size = 0;
      e.wdata = 0; e.be = 0; d = 0;
      if (ins[10:4] == 7'b0000111) kind = 1;
      else if (ins[10:7] == 4'b1010) kind = ins[0] ? 3 : 2;
      else if (ins[10:7] == 4'b0111) kind = 4;
      else if (ins[10:7] == 4'b1001) kind = 5;
      else kind = 0;
      case (kind)
         1: begin d = {3'b0, ins[3:0], 1'b0}; e.size = 2'd1; end
         2: begin d = {ins[6:1], 2'b0};       e.size = 2'd2; end
         3: begin d = {ins[6:1], 2'b0};       e.size = 2'd2; e.we = 1; end
         4: begin d = {1'b0, ins[6:0]};       e.size = 2'd0; e.we = 1; end
         5: begin d = {ins[6:0], 1'b0};       e.size = 2'd1; e.we = 1; end
         default: begin e.ill = 1; e.req = 0; end
      endcase
      e.addr = ep + {24'h0, d};
      case (e.size)
         2'd0: begin e.be = 4'b0001 << e.addr[1:0]; e.wdata = {4{r2[7:0]}}; end
         2'd1: begin e.be = e.addr[1] ? 4'b1100 : 4'b0011; e.wdata = {2{r2[15:0]}}; end
         default: begin e.be = 4'hF; e.wdata = r2; end
      endcase
      return e;
   endfunction

   // monitor: compares design activity against the queues
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_req || illegal) begin
            n_chk++;
            if (rq.size() == 0) begin
               n_fail++;
               $display("FAIL R7 unexpected request: req=%0b ill=%0b exp none", mem_req, illegal);
            end else begin
               req_t e;
               bit ok;
               e  = rq.pop_front();
               ok = (illegal == e.ill) && (mem_req == e.req);
               if (e.req) begin
                  ok = ok && (mem_we == e.we) && (mem_size == e.size) &&
                       (mem_addr == e.addr) && (mem_be == e.be);
                  if (e.we) ok = ok && (mem_wdata == e.wdata);
               end
               if (!ok) begin
                  n_fail++;
                  $display("FAIL %s: got ill=%0b req=%0b we=%0b sz=%0d a=%h be=%b wd=%h exp ill=%0b req=%0b we=%0b sz=%0d a=%h be=%b wd=%h",
                           e.tag, illegal, mem_req, mem_we, mem_size, mem_addr, mem_be, mem_wdata,
                           e.ill, e.req, e.we, e.size, e.addr, e.be, e.wdata);
               end
            end
         end
         if (rf_we) begin
            n_chk++;
            if (wq.size() == 0) begin
               n_fail++;
               $display("FAIL R9 unexpected writeback: idx=%0d data=%h exp none", rf_waddr, rf_wdata);
            end else begin
               wb_t w;
               w = wq.pop_front();
               if (rf_waddr != w.rid || rf_wdata != w.data) begin
                  n_fail++;
                  $display("FAIL %s: got idx=%0d data=%h exp idx=%0d data=%h",
                           w.tag, rf_waddr, rf_wdata, w.rid, w.data);
               end
            end
         end
      end
   end

   task automatic chk(input bit ok, input string msg, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %h exp %h", msg, got, exp);
      end
   endtask

   // driver: pushes the expected item, then presents the instruction for one cycle
   task automatic issue(input logic [15:0] ins, input logic [31:0] ep,
                        input logic [31:0] r2, input string tag);
      rq.push_back(model(ins, ep, r2, tag));
      @(posedge clk); #1;
      inst_valid = 1'b1; inst = ins; ep_val = ep; reg2_rdata = r2;
      @(posedge clk); #1;
      inst_valid = 1'b0;
   endtask

   task automatic load(input logic [15:0] ins, input logic [31:0] ep,
                       input logic [31:0] rd, input string tag);
      req_t e;
      wb_t  w;
      e = model(ins, ep, 32'h0, tag);
      issue(ins, ep, 32'h0, tag);
      w.tag = tag;
      w.rid = ins[15:11];
      if (e.size == 2'd1) w.data = e.addr[1] ? {16'h0, rd[31:16]} : {16'h0, rd[15:0]};
      else                w.data = rd;
      wq.push_back(w);
      mem_rvalid = 1'b1; mem_rdata = rd;
      @(posedge clk); #1;
      mem_rvalid = 1'b0;
   endtask

   task automatic stray_rvalid(input string tag);
      @(posedge clk); #1;
      mem_rvalid = 1'b1; mem_rdata = 32'hDEAD_BEEF;
      @(posedge clk); #1;
      mem_rvalid = 1'b0;
      @(negedge clk);
      chk(rf_we == 1'b0, tag, {31'h0, rf_we}, 32'h0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired: got %0d cycles exp under 100000", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      // R10 reset state
      repeat (2) @(negedge clk);
      chk(!mem_req && !illegal && !rf_we && mem_be == 4'h0, "R10 reset outputs",
          {28'h0, mem_req, illegal, rf_we, |mem_be}, 32'h0);
      @(posedge clk); #1;
      rst_n = 1'b1;

      // R2 halfword load, upper and lower lane
      load(e_ldh(5'd3, 4'd5), 32'h0000_1000, 32'hABCD_1234, "R2 R8 ldh upper half");
      load(e_ldh(5'd17, 4'd4), 32'h0000_1000, 32'hABCD_1234, "R2 R8 ldh lower half");
      load(e_ldh(5'd31, 4'd15), 32'h0000_2000, 32'h8765_FFFF, "R2 R8 ldh max disp");

      // R3 word loads, R1 register index
      load(e_ldw(5'd7, 6'd63), 32'h0000_2000, 32'hCAFE_F00D, "R3 R1 ldw max disp");
      load(e_ldw(5'd0, 6'd0), 32'h0001_0000, 32'h0102_0304, "R3 ldw zero disp");

      // R4 word stores, R1 wrap
      issue(e_stw(5'd9, 6'd1), 32'h0000_4000, 32'h1122_3344, "R4 stw");
      issue(e_stw(5'd9, 6'd2), 32'hFFFF_FFFC, 32'h5566_7788, "R1 R4 stw address wrap");

      // R5 byte stores on every lane
      for (int k = 0; k < 4; k++)
         issue(e_stb(5'd2, 7'(k)), 32'h0000_3000, 32'h0000_00A5 + 32'(k), "R5 stb lane");
      issue(e_stb(5'd2, 7'h7F), 32'h0000_3000, 32'hFFFF_FF3C, "R5 stb max disp");

      // R6 halfword stores
      issue(e_sth(5'd4, 7'h7F), 32'h0000_3000, 32'h9999_BEEF, "R6 sth max disp upper");
      issue(e_sth(5'd4, 7'h00), 32'h0000_3000, 32'h9999_1357, "R6 sth zero disp lower");

      // R7 unknown encodings
      issue(16'b00001_0110_0000011, 32'h0, 32'h0, "R7 illegal byte-load pattern");
      issue(16'b00001_0000_1100011, 32'h0, 32'h0, "R7 illegal near ldh");
      issue(16'b00001_1111_1111111, 32'h0, 32'h0, "R7 illegal all ones");
      issue(16'b00001_0000_0000000, 32'h0, 32'h0, "R7 illegal zero field");

      // R7 valid low: no activity even with a legal encoding present
      @(posedge clk); #1;
      inst = e_ldw(5'd1, 6'd1); inst_valid = 1'b0;
      @(negedge clk);
      chk(!mem_req && !illegal, "R7 idle with legal encoding", {30'h0, mem_req, illegal}, 32'h0);

      // R9 read data without an outstanding load
      stray_rvalid("R9 stray rvalid");
      issue(e_stw(5'd5, 6'd3), 32'h0000_5000, 32'h0BAD_F00D, "R9 R4 store before rvalid");
      stray_rvalid("R9 rvalid after store");

      repeat (4) @(posedge clk);
      #1;
      chk(rq.size() == 0 && wq.size() == 0, "R8 expectations drained",
          32'(rq.size() + wq.size()), 32'h0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule